// File: doc/BRIEF.md
# Masked Vector Reduction Unit

This block folds the active elements of a vector operand into one scalar. A command pulse supplies the operation, the vector length, a start index, a scalar seed, a packed mask and the effective register-group multipliers of the three operands. The accumulator begins at the seed. The unit then walks the source elements from index 0 upward, one per clock. It requests each element by index, and the element data must return in the same cycle. An element whose mask bit is clear leaves the accumulator unchanged.

When the walk ends, the unit presents the accumulator on the result port as a one-cycle valid pulse. At the same moment it pulses a request to clear the architectural start index. A command with a nonzero start index, or with an illegal group multiplier, produces an exception pulse in place of a result. Commands that arrive while a walk is in progress are ignored.

Top module: `vred_unit`

## Requirements
- R1: The accumulator is loaded from `seed` when a command is accepted. With every element masked off, the result equals the seed.
- R2: While busy, the unit requests one element per cycle, in ascending order starting at index 0. `elem_req` is high and `elem_idx` is the element being folded.
- R3: Element i is folded only when `mask[i]` is 1. Bit i of the packed mask is bit i&7 of mask byte i>>3. Elements whose bit is 0 are skipped.
- R4: `op_sel` selects the fold as follows: 0 sum (modulo 2^EW), 1 and, 2 or, 3 xor, 4 unsigned minimum, 5 signed minimum, 6 unsigned maximum, 7 signed maximum.
- R5: A command with a nonzero `vstart_idx` raises `exc` for one cycle, one cycle after the command. It produces no `res_valid`.
- R6: If any of `mul_dst`, `mul_src2`, `mul_src1` is 0 or greater than 64, the command raises `exc` and produces no result. A value of exactly 64 is legal.
- R7: `clr_start` pulses together with every `res_valid`. It does not pulse on an exception.
- R8: A command with `vl` equal to 0 returns the seed, with `res_valid` one cycle after the command.
- R9: For `vl` > 0, `res_valid` pulses vl+1 cycles after the command, which is the cycle after the last element. `res_data` holds its value until the next result.
- R10: A `start` pulse while `busy` is high is ignored. The running reduction finishes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command pulse |
| op_sel | input | 3 | Fold operation (R4) |
| vl | input | VL_W | Number of elements |
| vstart_idx | input | VL_W | Start index; must be zero |
| seed | input | EW | Initial accumulator value |
| mask | input | MAX_VL | Packed element mask |
| mul_dst | input | MUL_W | Effective group multiplier, destination |
| mul_src2 | input | MUL_W | Effective group multiplier, vector source |
| mul_src1 | input | MUL_W | Effective group multiplier, scalar source |
| elem_data | input | EW | Element value for `elem_idx`, same cycle |
| elem_req | output | 1 | An element is being consumed |
| elem_idx | output | IDX_W | Index of the element requested |
| busy | output | 1 | Reduction walk in progress |
| res_data | output | EW | Reduction result |
| res_valid | output | 1 | Result pulse |
| clr_start | output | 1 | Request to clear the start index |
| exc | output | 1 | Exception pulse |

## Verification
A command accepted at a clock edge yields `exc`, or the `res_valid` of a zero-length command, after exactly one more edge. A walk of vl elements yields its result after vl+1 edges. The bench drives the command at a falling edge and counts falling edges from there. At each count it checks that `elem_idx` matches the count. It confirms that `res_valid` is still low one count before the due cycle, that it is high with the expected value and `clr_start` at the due count, and that it has dropped one count later while `res_data` holds. Expected values come from a bench fold function over the same element, mask and seed data.

// File: rtl/vred_pkg.sv
package vred_pkg;

    typedef enum logic [2:0] {
        RED_SUM  = 3'd0,
        RED_AND  = 3'd1,
        RED_OR   = 3'd2,
        RED_XOR  = 3'd3,
        RED_MINU = 3'd4,
        RED_MIN  = 3'd5,
        RED_MAXU = 3'd6,
        RED_MAX  = 3'd7
    } red_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } red_st_e;

endpackage

// File: rtl/vred_alu.sv
module vred_alu
    import vred_pkg::*;
#(
    parameter int EW = 16
) (
    input  red_op_e       op,
    input  logic [EW-1:0] acc,
    input  logic [EW-1:0] elem,
    output logic [EW-1:0] res
);
    logic lt_u;
    logic lt_s;

    assign lt_u = elem < acc;
    assign lt_s = $signed(elem) < $signed(acc);

    always_comb begin
        unique case (op)
            RED_SUM:  res = acc + elem;
            RED_AND:  res = acc & elem;
            RED_OR:   res = acc | elem;
            RED_XOR:  res = acc ^ elem;
            RED_MINU: res = lt_u ? elem : acc;
            RED_MIN:  res = lt_s ? elem : acc;
            RED_MAXU: res = lt_u ? acc : elem;
            RED_MAX:  res = lt_s ? acc : elem;
            default:  res = acc;
        endcase
    end
endmodule

// File: rtl/vred_cfg_check.sv
module vred_cfg_check #(
    parameter int MUL_W   = 8,
    parameter int MUL_MAX = 64,
    parameter int N_OPND  = 3
) (
    input  logic [N_OPND-1:0][MUL_W-1:0] muls,
    output logic                         bad
);
    localparam logic [MUL_W-1:0] LIMIT = MUL_W'(MUL_MAX);

    logic [N_OPND-1:0] opnd_bad;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        assign opnd_bad[g] = (muls[g] == '0) || (muls[g] > LIMIT);
    end

    assign bad = |opnd_bad;
endmodule

// File: rtl/vred_unit.sv
module vred_unit
    import vred_pkg::*;
#(
    parameter int EW     = 16,
    parameter int MAX_VL = 32,
    parameter int MUL_W  = 8,
    parameter int VL_W   = $clog2(MAX_VL + 1),
    parameter int IDX_W  = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_sel,
    input  logic [VL_W-1:0]   vl,
    input  logic [VL_W-1:0]   vstart_idx,
    input  logic [EW-1:0]     seed,
    input  logic [MAX_VL-1:0] mask,
    input  logic [MUL_W-1:0]  mul_dst,
    input  logic [MUL_W-1:0]  mul_src2,
    input  logic [MUL_W-1:0]  mul_src1,
    input  logic [EW-1:0]     elem_data,
    output logic              elem_req,
    output logic [IDX_W-1:0]  elem_idx,
    output logic              busy,
    output logic [EW-1:0]     res_data,
    output logic              res_valid,
    output logic              clr_start,
    output logic              exc
);
    localparam int N_OPND = 3;

    typedef struct packed {
        red_st_e           st;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        red_op_e           op;
        logic [EW-1:0]     acc;
        logic [MAX_VL-1:0] msk;
        logic [EW-1:0]     res;
        logic              vld;
        logic              exc;
    } red_state_t;

    red_state_t s_d, s_q;

    logic          cfg_bad;
    logic [EW-1:0] fold_res;

    vred_cfg_check #(
        .MUL_W   (MUL_W),
        .MUL_MAX (64),
        .N_OPND  (N_OPND)
    ) u_cfg (
        .muls ({mul_dst, mul_src2, mul_src1}),
        .bad  (cfg_bad)
    );

    vred_alu #(
        .EW (EW)
    ) u_alu (
        .op   (s_q.op),
        .acc  (s_q.acc),
        .elem (elem_data),
        .res  (fold_res)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.exc = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    if ((vstart_idx != '0) || cfg_bad) begin
                        s_d.exc = 1'b1;
                    end else if (vl == '0) begin
                        s_d.res = seed;
                        s_d.vld = 1'b1;
                    end else begin
                        s_d.st   = ST_RUN;
                        s_d.idx  = '0;
                        s_d.last = IDX_W'(vl - 1'b1);
                        s_d.op   = red_op_e'(op_sel);
                        s_d.acc  = seed;
                        s_d.msk  = mask;
                    end
                end
            end
            ST_RUN: begin
                if (s_q.msk[s_q.idx]) begin
                    s_d.acc = fold_res;
                end
                if (s_q.idx == s_q.last) begin
                    s_d.res = s_d.acc;
                    s_d.vld = 1'b1;
                    s_d.st  = ST_IDLE;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st == ST_RUN);
    assign elem_req  = busy;
    assign elem_idx  = s_q.idx;
    assign res_data  = s_q.res;
    assign res_valid = s_q.vld;
    assign clr_start = s_q.vld;
    assign exc       = s_q.exc;
endmodule

// File: rtl/vred_checker.sv
module vred_checker #(
    parameter int MAX_VL = 32,
    parameter int MUL_W  = 8,
    parameter int VL_W   = $clog2(MAX_VL + 1),
    parameter int IDX_W  = $clog2(MAX_VL)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VL_W-1:0]  vstart_idx,
    input logic [MUL_W-1:0] mul_dst,
    input logic [MUL_W-1:0] mul_src2,
    input logic [MUL_W-1:0] mul_src1,
    input logic             elem_req,
    input logic [IDX_W-1:0] elem_idx,
    input logic             busy,
    input logic             res_valid,
    input logic             exc
);
    logic mul_illegal;
    assign mul_illegal = (mul_dst == '0) || (mul_dst > MUL_W'(64)) ||
                         (mul_src2 == '0) || (mul_src2 > MUL_W'(64)) ||
                         (mul_src1 == '0) || (mul_src1 > MUL_W'(64));

    p_walk_begins_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (elem_idx == '0));

    p_walk_ascends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_req && $past(elem_req)) |-> (elem_idx == $past(elem_idx) + 1'b1));

    p_start_rejected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (vstart_idx != '0)) |=> (exc && !res_valid));

    p_bad_multiplier_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mul_illegal) |=> (exc && !res_valid));

    p_result_after_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> res_valid);

    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> !exc);

    p_no_result_with_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && exc));
endmodule

bind vred_unit vred_checker #(
    .MAX_VL (MAX_VL),
    .MUL_W  (MUL_W),
    .VL_W   (VL_W),
    .IDX_W  (IDX_W)
) u_vred_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vstart_idx (vstart_idx),
    .mul_dst    (mul_dst),
    .mul_src2   (mul_src2),
    .mul_src1   (mul_src1),
    .elem_req   (elem_req),
    .elem_idx   (elem_idx),
    .busy       (busy),
    .res_valid  (res_valid),
    .exc        (exc)
);

// File: tb/sim_vred_unit.sv
module sim_vred_unit;
    localparam int EW     = 16;
    localparam int MAX_VL = 32;
    localparam int MUL_W  = 8;
    localparam int VL_W   = $clog2(MAX_VL + 1);
    localparam int IDX_W  = $clog2(MAX_VL);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        op_sel = '0;
    logic [VL_W-1:0]   vl = '0;
    logic [VL_W-1:0]   vstart_idx = '0;
    logic [EW-1:0]     seed = '0;
    logic [MAX_VL-1:0] mask = '0;
    logic [MUL_W-1:0]  mul_dst = 8'd1;
    logic [MUL_W-1:0]  mul_src2 = 8'd1;
    logic [MUL_W-1:0]  mul_src1 = 8'd1;
    logic [EW-1:0]     elem_data;
    logic              elem_req;
    logic [IDX_W-1:0]  elem_idx;
    logic              busy;
    logic [EW-1:0]     res_data;
    logic              res_valid;
    logic              clr_start;
    logic              exc;

    logic [EW-1:0] vec [MAX_VL];

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    always_comb elem_data = vec[elem_idx];

    vred_unit #(.EW(EW), .MAX_VL(MAX_VL), .MUL_W(MUL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .vl(vl),
        .vstart_idx(vstart_idx), .seed(seed), .mask(mask), .mul_dst(mul_dst),
        .mul_src2(mul_src2), .mul_src1(mul_src1), .elem_data(elem_data),
        .elem_req(elem_req), .elem_idx(elem_idx), .busy(busy),
        .res_data(res_data), .res_valid(res_valid), .clr_start(clr_start),
        .exc(exc)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] ref_fold(input logic [2:0] op,
                                               input logic [EW-1:0] a,
                                               input logic [EW-1:0] e);
        case (op)
            3'd0: return a + e;
            3'd1: return a & e;
            3'd2: return a | e;
            3'd3: return a ^ e;
            3'd4: return (e < a) ? e : a;
            3'd5: return ($signed(e) < $signed(a)) ? e : a;
            3'd6: return (e > a) ? e : a;
            default: return ($signed(e) > $signed(a)) ? e : a;
        endcase
    endfunction

    function automatic logic [EW-1:0] ref_reduce(input logic [2:0] op, input int n,
                                                 input logic [EW-1:0] s,
                                                 input logic [MAX_VL-1:0] m);
        logic [EW-1:0] a = s;
        for (int i = 0; i < n; i++) begin
            if (m[i >> 3 << 3 | (i & 7)]) a = ref_fold(op, a, vec[i]);
        end
        return a;
    endfunction

    // Issue one legal-length command and check timing, ordering and value.
    // inj > 0 pulses a conflicting start at that count while busy (R10).
    task automatic run_op(input logic [2:0] op, input int n, input logic [EW-1:0] s,
                          input logic [MAX_VL-1:0] m, input int inj, input string tag);
        logic [EW-1:0] exp_v;
        bit order_ok = 1'b1;
        exp_v = ref_reduce(op, n, s, m);
        @(negedge clk);
        op_sel = op; vl = VL_W'(n); vstart_idx = '0; seed = s; mask = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(res_valid && clr_start && !exc, {tag, " R8 valid"}, res_valid, 1);
            chk(res_data == exp_v, {tag, " R8 data"}, res_data, exp_v);
        end else begin
            for (int j = 1; j <= n; j++) begin
                if (!(elem_req && elem_idx == IDX_W'(j - 1))) order_ok = 1'b0;
                if (j == inj) begin
                    op_sel = ~op; vl = 1; seed = ~s; mask = '1; start = 1'b1;
                end else begin
                    start = 1'b0;
                end
                if (j < n) @(negedge clk);
            end
            start = 1'b0;
            chk(order_ok, {tag, " R2 order"}, order_ok, 1);
            chk(!res_valid, {tag, " R9 early"}, res_valid, 0);
            @(negedge clk);
            chk(res_valid && !exc, {tag, " R9 valid"}, res_valid, 1);
            chk(clr_start, {tag, " R7 clear"}, clr_start, 1);
            chk(res_data == exp_v, {tag, " R4 data"}, res_data, exp_v);
        end
        @(negedge clk);
        chk(!res_valid && !busy, {tag, " R9 pulse"}, res_valid, 0);
        chk(res_data == exp_v, {tag, " R9 hold"}, res_data, exp_v);
    endtask

    task automatic run_bad(input logic [VL_W-1:0] vs, input logic [MUL_W-1:0] md,
                           input logic [MUL_W-1:0] m2, input logic [MUL_W-1:0] m1,
                           input string tag);
        logic [EW-1:0] prev;
        @(negedge clk);
        prev = res_data;
        op_sel = 3'd0; vl = 5; vstart_idx = vs; seed = 16'h1234; mask = '1;
        mul_dst = md; mul_src2 = m2; mul_src1 = m1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(exc && !res_valid, {tag, " exc"}, exc, 1);
        chk(!clr_start, {tag, " R7 no clear"}, clr_start, 0);
        @(negedge clk);
        chk(!exc && !busy && res_data == prev, {tag, " no result"}, res_data, prev);
        vstart_idx = '0; mul_dst = 1; mul_src2 = 1; mul_src1 = 1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MAX_VL; i++) vec[i] = EW'($urandom);
        repeat (3) @(negedge clk);
        chk(!res_valid && !exc && !busy && !elem_req && !clr_start,
            "reset outputs", {res_valid, exc, busy}, 0);
        rst_n = 1'b1;

        // R8: zero length returns the seed
        run_op(3'd0, 0, 16'hBEEF, '1, 0, "vl0");
        // R1 and R3: every element masked off
        run_op(3'd0, 12, 16'h0A5A, '0, 0, "R1 all-off");
        // R3: only element 9 active (byte 1, bit 1)
        for (int i = 0; i < MAX_VL; i++) vec[i] = EW'(i + 1);
        run_op(3'd0, 16, 16'h0000, 32'h0000_0200, 0, "R3 single");
        // R4: signed versus unsigned min and max on mixed signs
        vec[0] = 16'h8000; vec[1] = 16'h7FFF; vec[2] = 16'hFFFF; vec[3] = 16'h0001;
        for (int op = 4; op < 8; op++) run_op(3'(op), 4, 16'h0100, '1, 0, "R4 minmax");
        // R4: sum wraps modulo 2^EW
        vec[0] = 16'hFFFF; vec[1] = 16'h0003;
        run_op(3'd0, 2, 16'h0001, '1, 0, "R4 wrap");
        // full length
        for (int i = 0; i < MAX_VL; i++) vec[i] = EW'($urandom);
        run_op(3'd3, MAX_VL, 16'h5555, '1, 0, "full");
        // R10: start while busy is ignored
        run_op(3'd0, 10, 16'h0010, 32'h0000_03F5, 4, "R10 busy");

        // R5 and R6 rejections; 64 legal
        run_bad(VL_W'(3), 1, 1, 1, "R5 vstart");
        run_bad('0, 0, 1, 1, "R6 dst zero");
        run_bad('0, 1, 65, 1, "R6 src2 65");
        run_bad('0, 1, 1, 8'd200, "R6 src1 200");
        @(negedge clk);
        mul_dst = 64; mul_src2 = 64; mul_src1 = 64;
        run_op(3'd2, 6, 16'h0000, '1, 0, "R6 legal 64");
        mul_dst = 1; mul_src2 = 1; mul_src1 = 1;

        // constrained random
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < MAX_VL; i++) vec[i] = EW'($urandom);
            run_op(3'($urandom_range(0, 7)), int'($urandom_range(1, MAX_VL)),
                   EW'($urandom), MAX_VL'($urandom), 0, "rand R3 R4");
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(100000 * 20);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule